// File: doc/BRIEF.md
# Bit-Stream Field Writer

This block appends a field of 1 to 16 bits to a bit stream held in two 16-bit memory banks. Stream word k sits in bank k mod 2 at bank address k/2. The stream position is a word index plus a 4-bit bit offset inside that word. A field that starts near the end of a word runs on into the next word.

Each write is a read-modify-write on a 32-bit pair: the word at the current index and the word after it. The block reads both words in one cycle, one from each bank, and swaps them into stream order when the index is odd. It shifts the new field into place, clears and fills only the target bits, and writes both words back in one cycle. It then advances the position by the field length. Two fill orders are supported. One fills each word from its most significant bit down. The other fills from the least significant bit up. The first order takes one more cycle because its shift amount needs an extra alignment step.

Top module: `bsw_writer`

## Requirements
- R1: After reset the block is idle: busy_o, done_o and all bank enables are 0, and wp_o and bp_o are 0.
- R2: A seek_i pulse while idle loads seek_wp_i and seek_bp_i into wp_o and bp_o on the next cycle. A seek_i while busy is ignored.
- R3: One cycle after an accepted start_i, both bank read enables are high in the same cycle. Stream word k is addressed in bank k[0] at address k>>1, for the words at index wp_o and (wp_o+1) mod 2^WAW.
- R4: The write-back raises both bank write enables in the same single cycle, at the same bank addresses that were read.
- R5: With mode_i=0, stream bit offset j of a word is word bit 15-j, and field bit n-1 is placed first, at the current position.
- R6: With mode_i=1, stream bit offset j of a word is word bit j, and field bit 0 is placed first, at the current position.
- R7: Every bit of the two words outside the n-bit target window is written back unchanged.
- R8: len_i encodes the field length as n-1, so 0 writes 1 bit and 15 writes 16 bits. A field may cross from the word at wp_o into the next word.
- R9: When a write completes, bp_o becomes (bp_o+n) mod 16 and the carry is added to wp_o, which wraps modulo 2^WAW. Otherwise the pointer changes only by seek.
- R10: done_o is a one-cycle pulse in the cycle after the write-back: 5 cycles after start is accepted for mode 1, 6 cycles for mode 0. A start_i while busy is ignored.
- R11: Bits of data_i at and above position n have no effect on memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a field write (accepted when idle) |
| data_i | input | WORD_W | Field value, low n bits used |
| len_i | input | BPW | Field length minus one |
| mode_i | input | 1 | Fill order: 0 MSB first, 1 LSB first |
| seek_i | input | 1 | Load the stream position (accepted when idle) |
| seek_wp_i | input | WAW | Word index to load |
| seek_bp_i | input | BPW | Bit offset to load |
| b0_rd_o | output | 1 | Bank 0 read enable |
| b0_we_o | output | 1 | Bank 0 write enable |
| b0_addr_o | output | WAW-1 | Bank 0 address |
| b0_wdata_o | output | WORD_W | Bank 0 write data |
| b0_rdata_i | input | WORD_W | Bank 0 read data, one cycle after the read enable |
| b1_rd_o | output | 1 | Bank 1 read enable |
| b1_we_o | output | 1 | Bank 1 write enable |
| b1_addr_o | output | WAW-1 | Bank 1 address |
| b1_wdata_o | output | WORD_W | Bank 1 write data |
| b1_rdata_i | input | WORD_W | Bank 1 read data, one cycle after the read enable |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| wp_o | output | WAW | Current word index |
| bp_o | output | BPW | Current bit offset in the word |

## Verification
The assertions cover the cycle-level framing on every cycle. Both banks read together right after an accepted start. Both write enables rise together and never alongside a read. Bank addresses stay fixed from read to write-back, the read addresses are one pair of adjacent words, done pulses once after the write, and the pointer moves only at a write or an idle seek. Bit placement for each fill order, preservation of neighbouring bits, masking of data bits above the length, the exact pointer arithmetic, the wrap of the last word into word 0 and the exact latency per mode can only be shown by the bench's scenarios. The bench compares the whole memory and the pointer against its own model after each write.

// File: rtl/bsw_pkg.sv
package bsw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_CAP,
    ST_ALN,
    ST_MRG,
    ST_WR,
    ST_DONE
  } bsw_state_e;

  typedef enum logic {
    MODE_MSB = 1'b0,
    MODE_LSB = 1'b1
  } bsw_mode_e;
endpackage

// File: rtl/bsw_bank_map.sv
// Stream word k lives in bank k[0] at address k>>1.
module bsw_bank_map #(
  parameter int WAW = 6,
  localparam int BAW = WAW - 1
) (
  input  logic [WAW-1:0] wp_i,
  output logic           swap_o,
  output logic [BAW-1:0] b0_addr_o,
  output logic [BAW-1:0] b1_addr_o
);
  logic [BAW-1:0] base;

  assign base      = wp_i[WAW-1:1];
  assign swap_o    = wp_i[0];
  // odd index: first word in bank 1, next word in bank 0 one row up
  assign b0_addr_o = swap_o ? BAW'(base + BAW'(1)) : base;
  assign b1_addr_o = base;
endmodule

// File: rtl/bsw_merge.sv
// Clears an n-bit window at shift sh_i and fills it with the low n bits of data_i.
module bsw_merge #(
  parameter int WORD_W = 16,
  localparam int LW = $clog2(WORD_W),
  localparam int PAIR_W = 2 * WORD_W,
  localparam int PW = $clog2(PAIR_W)
) (
  input  logic [PAIR_W-1:0] pair_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic [LW-1:0]     len_i,
  input  logic [PW-1:0]     sh_i,
  output logic [PAIR_W-1:0] pair_o
);
  logic [LW-1:0]     inv_len;
  logic [WORD_W-1:0] ones;
  logic [PAIR_W-1:0] mask;
  logic [PAIR_W-1:0] fld;

  assign inv_len = LW'(WORD_W - 1) - len_i;
  assign ones    = {WORD_W{1'b1}} >> inv_len;
  assign mask    = {{WORD_W{1'b0}}, ones} << sh_i;
  assign fld     = {{WORD_W{1'b0}}, data_i & ones} << sh_i;
  assign pair_o  = (pair_i & ~mask) | fld;
endmodule

// File: rtl/bsw_ptr.sv
module bsw_ptr #(
  parameter int WORD_W = 16,
  parameter int WAW = 6,
  localparam int BPW = $clog2(WORD_W)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           seek_en_i,
  input  logic [WAW-1:0] seek_wp_i,
  input  logic [BPW-1:0] seek_bp_i,
  input  logic           adv_en_i,
  input  logic [BPW-1:0] len_i,
  output logic [WAW-1:0] wp_o,
  output logic [BPW-1:0] bp_o
);
  logic [WAW-1:0] wp_q;
  logic [BPW-1:0] bp_q;
  logic [BPW:0]   sum;

  // len_i holds n-1, so n = len_i + 1
  assign sum = {1'b0, bp_q} + {1'b0, len_i} + (BPW+1)'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
      bp_q <= '0;
    end else if (seek_en_i) begin
      wp_q <= seek_wp_i;
      bp_q <= seek_bp_i;
    end else if (adv_en_i) begin
      bp_q <= sum[BPW-1:0];
      wp_q <= wp_q + WAW'(sum[BPW]);
    end
  end

  assign wp_o = wp_q;
  assign bp_o = bp_q;
endmodule

// File: rtl/bsw_writer.sv
module bsw_writer
  import bsw_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int WAW = 6,
  localparam int BPW = $clog2(WORD_W),
  localparam int BAW = WAW - 1,
  localparam int PAIR_W = 2 * WORD_W,
  localparam int PW = $clog2(PAIR_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic [BPW-1:0]    len_i,
  input  logic              mode_i,
  input  logic              seek_i,
  input  logic [WAW-1:0]    seek_wp_i,
  input  logic [BPW-1:0]    seek_bp_i,
  output logic              b0_rd_o,
  output logic              b0_we_o,
  output logic [BAW-1:0]    b0_addr_o,
  output logic [WORD_W-1:0] b0_wdata_o,
  input  logic [WORD_W-1:0] b0_rdata_i,
  output logic              b1_rd_o,
  output logic              b1_we_o,
  output logic [BAW-1:0]    b1_addr_o,
  output logic [WORD_W-1:0] b1_wdata_o,
  input  logic [WORD_W-1:0] b1_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WAW-1:0]    wp_o,
  output logic [BPW-1:0]    bp_o
);
  bsw_state_e        state_q;
  bsw_mode_e         mode_q;
  logic [WORD_W-1:0] data_q;
  logic [BPW-1:0]    len_q;
  logic [PW-1:0]     sh_q;
  logic [PAIR_W-1:0] pair_q;
  logic [PAIR_W-1:0] merged;

  logic              swap;
  logic [WAW-1:0]    wp;
  logic [BPW-1:0]    bp;
  logic [WORD_W-1:0] first_w, second_w;
  logic [WORD_W-1:0] wr_first, wr_second;
  logic              idle;

  assign idle = (state_q == ST_IDLE);

  bsw_ptr #(.WORD_W(WORD_W), .WAW(WAW)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .seek_en_i (seek_i && idle),
    .seek_wp_i (seek_wp_i),
    .seek_bp_i (seek_bp_i),
    .adv_en_i  (state_q == ST_WR),
    .len_i     (len_q),
    .wp_o      (wp),
    .bp_o      (bp)
  );

  bsw_bank_map #(.WAW(WAW)) u_map (
    .wp_i      (wp),
    .swap_o    (swap),
    .b0_addr_o (b0_addr_o),
    .b1_addr_o (b1_addr_o)
  );

  bsw_merge #(.WORD_W(WORD_W)) u_merge (
    .pair_i (pair_q),
    .data_i (data_q),
    .len_i  (len_q),
    .sh_i   (sh_q),
    .pair_o (merged)
  );

  // stream order of the returned words
  assign first_w  = swap ? b1_rdata_i : b0_rdata_i;
  assign second_w = swap ? b0_rdata_i : b1_rdata_i;

  // MSB mode holds {first,second}; LSB mode holds {second,first}
  assign wr_first  = (mode_q == MODE_LSB) ? pair_q[WORD_W-1:0] : pair_q[PAIR_W-1:WORD_W];
  assign wr_second = (mode_q == MODE_LSB) ? pair_q[PAIR_W-1:WORD_W] : pair_q[WORD_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_MSB;
      data_q  <= '0;
      len_q   <= '0;
      sh_q    <= '0;
      pair_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            mode_q  <= bsw_mode_e'(mode_i);
            data_q  <= data_i;
            len_q   <= len_i;
            state_q <= ST_RD;
          end
        end
        ST_RD: state_q <= ST_CAP;
        ST_CAP: begin
          pair_q  <= (mode_q == MODE_LSB) ? {second_w, first_w} : {first_w, second_w};
          sh_q    <= PW'(bp);
          state_q <= (mode_q == MODE_LSB) ? ST_MRG : ST_ALN;
        end
        ST_ALN: begin
          // MSB mode: window's low end sits at 2W - bp - n
          sh_q    <= PW'(PAIR_W - 1) - sh_q - PW'(len_q);
          state_q <= ST_MRG;
        end
        ST_MRG: begin
          pair_q  <= merged;
          state_q <= ST_WR;
        end
        ST_WR:   state_q <= ST_DONE;
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign b0_rd_o    = (state_q == ST_RD);
  assign b1_rd_o    = (state_q == ST_RD);
  assign b0_we_o    = (state_q == ST_WR);
  assign b1_we_o    = (state_q == ST_WR);
  assign b0_wdata_o = swap ? wr_second : wr_first;
  assign b1_wdata_o = swap ? wr_first : wr_second;
  assign busy_o     = !idle;
  assign done_o     = (state_q == ST_DONE);
  assign wp_o       = wp;
  assign bp_o       = bp;
endmodule

// File: rtl/bsw_writer_chk.sv
module bsw_writer_chk #(
  parameter int WORD_W = 16,
  parameter int WAW = 6,
  localparam int BPW = $clog2(WORD_W),
  localparam int BAW = WAW - 1
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic           seek_i,
  input logic           busy_o,
  input logic           done_o,
  input logic           b0_rd_o,
  input logic           b1_rd_o,
  input logic           b0_we_o,
  input logic           b1_we_o,
  input logic [BAW-1:0] b0_addr_o,
  input logic [BAW-1:0] b1_addr_o,
  input logic [WAW-1:0] wp_o,
  input logic [BPW-1:0] bp_o
);
  a_r3_read_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (b0_rd_o && b1_rd_o));

  a_r3_adjacent_rows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b0_rd_o |-> ((b0_addr_o == b1_addr_o) || (b0_addr_o == BAW'(b1_addr_o + BAW'(1)))));

  a_r4_write_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b0_we_o || b1_we_o) |-> (b0_we_o && b1_we_o && !b0_rd_o && !b1_rd_o));

  a_r4_addr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o && !b0_we_o) |=> ($stable(b0_addr_o) && $stable(b1_addr_o)));

  a_r10_done_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b0_we_o |=> done_o);

  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_ptr_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!b0_we_o && !(seek_i && !busy_o)) |=> ($stable(wp_o) && $stable(bp_o)));
endmodule

bind bsw_writer bsw_writer_chk #(.WORD_W(WORD_W), .WAW(WAW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .seek_i    (seek_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .b0_rd_o   (b0_rd_o),
  .b1_rd_o   (b1_rd_o),
  .b0_we_o   (b0_we_o),
  .b1_we_o   (b1_we_o),
  .b0_addr_o (b0_addr_o),
  .b1_addr_o (b1_addr_o),
  .wp_o      (wp_o),
  .bp_o      (bp_o)
);

// File: tb/bsw_writer_test.sv
module bsw_writer_test;
  localparam int W = 16;
  localparam int WAW = 6;
  localparam int BPW = 4;
  localparam int BAW = WAW - 1;
  localparam int NW = 1 << WAW;
  localparam int NR = 1 << BAW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] data = '0;
  logic [BPW-1:0] len = '0;
  logic mode = 1'b0;
  logic seek = 1'b0;
  logic [WAW-1:0] seek_wp = '0;
  logic [BPW-1:0] seek_bp = '0;
  logic b0_rd, b0_we, b1_rd, b1_we, busy, done;
  logic [BAW-1:0] b0_addr, b1_addr;
  logic [W-1:0] b0_wdata, b1_wdata;
  logic [W-1:0] b0_rdata = '0, b1_rdata = '0;
  logic [WAW-1:0] wp;
  logic [BPW-1:0] bp;

  logic [W-1:0] mem0 [NR];
  logic [W-1:0] mem1 [NR];
  logic [W-1:0] refm [NW];
  int exp_wp, exp_bp;
  int tests = 0, fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  bsw_writer uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .data_i(data), .len_i(len),
    .mode_i(mode), .seek_i(seek), .seek_wp_i(seek_wp), .seek_bp_i(seek_bp),
    .b0_rd_o(b0_rd), .b0_we_o(b0_we), .b0_addr_o(b0_addr), .b0_wdata_o(b0_wdata),
    .b0_rdata_i(b0_rdata), .b1_rd_o(b1_rd), .b1_we_o(b1_we), .b1_addr_o(b1_addr),
    .b1_wdata_o(b1_wdata), .b1_rdata_i(b1_rdata), .busy_o(busy), .done_o(done),
    .wp_o(wp), .bp_o(bp)
  );

  always @(posedge clk) begin
    if (b0_rd) b0_rdata <= mem0[b0_addr];
    if (b1_rd) b1_rdata <= mem1[b1_addr];
    if (b0_we) mem0[b0_addr] <= b0_wdata;
    if (b1_we) mem1[b1_addr] <= b1_wdata;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int row_of(input int k);
    return (k % NW) >> 1;
  endfunction

  task automatic check_mem(input string req);
    int bad = 0, first = -1;
    for (int k = 0; k < NW; k++) begin
      logic [W-1:0] got;
      got = (k % 2 == 0) ? mem0[k >> 1] : mem1[k >> 1];
      if (got !== refm[k]) begin
        bad++;
        if (first < 0) first = k;
      end
    end
    if (first < 0) check(1'b1, req, 0, 0);
    else check(1'b0, req, (first % 2 == 0) ? mem0[first >> 1] : mem1[first >> 1], refm[first]);
  endtask

  task automatic do_seek(input int w, input int b);
    @(negedge clk);
    seek = 1'b1; seek_wp = WAW'(w); seek_bp = BPW'(b);
    @(negedge clk);
    seek = 1'b0;
    exp_wp = w; exp_bp = b;
    check(wp == WAW'(w) && bp == BPW'(b), "R2 seek load", {wp, bp}, (w << 4) | b);
  endtask

  // one field write; poke drives seek and start while busy
  task automatic do_write(input logic [W-1:0] d, input int n, input bit m, input bit poke);
    int cyc, we_cnt, e0, e1, k1;
    k1 = (exp_wp + 1) % NW;
    e0 = (exp_wp % 2 == 0) ? row_of(exp_wp) : row_of(k1);
    e1 = (exp_wp % 2 == 1) ? row_of(exp_wp) : row_of(k1);
    @(negedge clk);
    data = d; len = BPW'(n - 1); mode = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0; cyc = 1; we_cnt = 0;
    check(b0_rd && b1_rd && int'(b0_addr) == e0 && int'(b1_addr) == e1,
          "R3 pair read", {b0_rd, b1_rd, b0_addr, b1_addr}, {2'b11, BAW'(e0), BAW'(e1)});
    while (!done && cyc < 20) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 2) begin
        seek = 1'b1; seek_wp = WAW'(exp_wp + 7); seek_bp = BPW'(exp_bp + 3); start = 1'b1;
      end
      if (poke && cyc == 3) begin
        seek = 1'b0; start = 1'b0;
      end
      if (b0_we || b1_we) begin
        we_cnt++;
        check(b0_we && b1_we && int'(b0_addr) == e0 && int'(b1_addr) == e1,
              "R4 write-back", {b0_we, b1_we, b0_addr, b1_addr}, {2'b11, BAW'(e0), BAW'(e1)});
      end
    end
    check(done && cyc == (m ? 5 : 6), "R10 latency", cyc, m ? 5 : 6);
    check(we_cnt == 1, "R4 single write cycle", we_cnt, 1);
    for (int i = 0; i < n; i++) begin
      int j, wd, pos;
      j = exp_bp + i;
      wd = (exp_wp + j / W) % NW;
      pos = m ? (j % W) : (W - 1 - (j % W));
      refm[wd][pos] = m ? d[i] : d[n - 1 - i];
    end
    exp_bp = exp_bp + n;
    exp_wp = (exp_wp + exp_bp / W) % NW;
    exp_bp = exp_bp % W;
    check(int'(wp) == exp_wp && int'(bp) == exp_bp, "R9 pointer advance",
          {wp, bp}, (exp_wp << 4) | exp_bp);
    check_mem(m ? "R6 R7 R11 lsb-first merge" : "R5 R7 R11 msb-first merge");
    @(negedge clk);
    check(!done && !busy && !b0_rd && !b1_rd, "R10 single done, busy start ignored",
          {done, busy, b0_rd}, 0);
  endtask

  task automatic t_reset;
    check(!busy && !done && !b0_rd && !b1_rd && !b0_we && !b1_we && wp == '0 && bp == '0,
          "R1 reset state", {busy, done, b0_rd, b1_rd, b0_we, b1_we, wp, bp}, 0);
  endtask

  task automatic t_msb_run;
    do_seek(0, 0);
    do_write(16'h0015, 5, 1'b0, 1'b0);
    do_write(16'hBEEF, 16, 1'b0, 1'b0);   // R8 crosses word boundary
    do_write(16'hF123, 12, 1'b0, 1'b0);   // R11 garbage above n
  endtask

  task automatic t_busy_ignore;
    do_seek(10, 15);
    do_write(16'h1234, 16, 1'b0, 1'b1);   // R2 seek and R10 start during op
    do_seek(62, 15);
    do_write(16'h8001, 16, 1'b1, 1'b1);
  endtask

  task automatic t_lsb_run;
    do_seek(20, 0);
    do_write(16'h0005, 3, 1'b1, 1'b0);
    do_write(16'hA5C3, 16, 1'b1, 1'b0);
    do_write(16'hFFFF, 14, 1'b1, 1'b0);
    do_write(16'h0000, 1, 1'b1, 1'b0);
  endtask

  task automatic t_wrap;
    do_seek(63, 8);
    do_write(16'hC3A5, 16, 1'b0, 1'b0);   // R9 wrap to word 0
    do_write(16'h0001, 1, 1'b1, 1'b0);
    do_write(16'h7E00, 9, 1'b0, 1'b0);
  endtask

  initial begin
    for (int k = 0; k < NW; k++) begin
      logic [W-1:0] v;
      v = W'(k * 40503) ^ 16'h5A5A;
      refm[k] = v;
      if (k % 2 == 0) mem0[k >> 1] = v;
      else mem1[k >> 1] = v;
    end
    exp_wp = 0; exp_bp = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_msb_run();
    t_busy_ignore();
    t_lsb_run();
    t_wrap();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule